// File: doc/BRIEF.md
# UART FIFO and Status Tracker

This block sits between a UART's register interface and its bit-level shifters. Software pushes transmit bytes with a write to the transmit-data register and pops received bytes with a read of the receive-data register. A FIFO-control register holds one fill threshold for each direction and two self-clearing flush bits. Toward the line, a byte-wide valid/ready stream feeds the transmit shifter, and a second stream takes bytes from the receive shifter.

Both queues are 16 bytes deep by default. Each queue is a small state machine with three states, FILL_EMPTY, FILL_PARTIAL and FILL_FULL. The transitions are: a push from FILL_EMPTY goes to FILL_PARTIAL; a push that fills the last slot goes from FILL_PARTIAL to FILL_FULL; a pop that removes the last entry goes from FILL_PARTIAL to FILL_EMPTY; a pop from FILL_FULL goes to FILL_PARTIAL; a flush from any state goes to FILL_EMPTY. The full and empty flags come from these states, and the status flags are built from the flags.

The block sends single-cycle events to an interrupt bank: transmit watermark, transmit empty, receive watermark and receive overflow. A level output shows the pending transmit-watermark state. Each event is registered and goes high in the cycle after its cause.

Register map, word index on `reg_addr`: 0 control, 1 status, 2 receive data, 3 transmit data, 4 FIFO control, 5 FIFO status. Any other index reads as zero. The `reg_rdata` port is combinational, is valid while `reg_re` is high, and is zero otherwise.

Top module: `uart_fifo_tracker`

## Requirements
- R1: A write to index 3 pushes `reg_wdata[7:0]` into the transmit queue. If the queue already holds 16 bytes, the byte is dropped and the queue is unchanged. A read of index 5 returns the transmit level in bits [4:0] and the receive level in bits [20:16].
- R2: The transmit threshold sits in FIFO-control bits [20:16]. A push that leaves the level at or above the threshold pulses `evt_tx_wmark` in the next cycle and sets `tx_wmark_pend`. A drain that leaves the level below the threshold clears `tx_wmark_pend`. A transmit flush also clears it.
- R3: Control bit 0 enables transmit. `tx_valid` is high exactly when transmit is enabled and the queue is not empty. `tx_data` presents the bytes in push order, and a byte leaves on `tx_valid && tx_ready`.
- R4: The status word has these bits: bit0 transmit full (level equals the depth), bit2 transmit empty, bit3 transmit idle (equal to `!tx_valid`). A drain that takes the level to zero pulses `evt_tx_empty`, unless a push comes in the same cycle.
- R5: FIFO-control bit1 flushes the transmit queue and bit0 flushes the receive queue, and the level is zero in the next cycle. The flush bits read back as 0. The thresholds read back as written.
- R6: Control bit 1 enables receive. `rx_ready` is high exactly when receive is enabled and the receive queue is not full. Status bit1 is receive full.
- R7: A read of index 2 returns the oldest received byte, or 0 when the queue is empty. The read pops that byte only when receive is enabled.
- R8: Status bit4 (receive idle) and bit5 (receive empty) both clear when a byte is accepted. Both set again when a read pops the last byte, or when the receive queue is flushed.
- R9: After reset the status word is 0x3C, both levels are 0, control and thresholds are 0, and all events are low.
- R10: When `rx_valid` is high while receive is enabled and the receive queue is full, the byte is dropped and `evt_rx_ovf` pulses in the next cycle.
- R11: The receive threshold sits in FIFO-control bits [12:8]. An accepted byte that leaves the receive level at or above it pulses `evt_rx_wmark` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, zero when not reading |
| tx_valid | output | 1 | Byte available to the transmit shifter |
| tx_ready | input | 1 | Transmit shifter takes the byte |
| tx_data | output | 8 | Oldest transmit byte |
| rx_valid | input | 1 | Receive shifter offers a byte |
| rx_ready | output | 1 | Receive queue accepts the byte |
| rx_data | input | 8 | Received byte |
| evt_tx_wmark | output | 1 | Transmit watermark event |
| evt_tx_empty | output | 1 | Transmit queue drained event |
| evt_rx_wmark | output | 1 | Receive watermark event |
| evt_rx_ovf | output | 1 | Receive overflow event |
| tx_wmark_pend | output | 1 | Pending transmit watermark state |

## Verification
Two pairs of operations can land in the same cycle. A software push to the transmit queue can coincide with a line-side drain, and a software pop of the receive queue can coincide with a line-side accept. In both cases the level stays the same, and the watermark and empty decisions must be taken on that resulting level. The random phase holds `tx_ready` and `rx_valid` high with varying bias while register pushes and pops are issued, so these collisions happen many times, including at the full and threshold boundaries. A bench model applies the same cycle rules, and the bench compares every event, the pending bit and each register read-back against that model.

// File: rtl/uft_pkg.sv
package uft_pkg;
    typedef enum logic [1:0] {
        FILL_EMPTY   = 2'd0,
        FILL_PARTIAL = 2'd1,
        FILL_FULL    = 2'd2
    } fill_state_e;

    localparam logic [2:0] ADDR_CTRL  = 3'd0;
    localparam logic [2:0] ADDR_STAT  = 3'd1;
    localparam logic [2:0] ADDR_RDATA = 3'd2;
    localparam logic [2:0] ADDR_WDATA = 3'd3;
    localparam logic [2:0] ADDR_FCTRL = 3'd4;
    localparam logic [2:0] ADDR_FSTAT = 3'd5;

    localparam int THR_W      = 5;
    localparam int TX_THR_LSB = 16;
    localparam int RX_THR_LSB = 8;
    localparam int TX_LVL_LSB = 0;
    localparam int RX_LVL_LSB = 16;
endpackage

// File: rtl/uft_byte_fifo.sv
module uft_byte_fifo
    import uft_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] head,
    output logic [LVL_W-1:0] level,
    output logic             is_empty,
    output logic             is_full
);
    localparam logic [LVL_W-1:0] LVL_ONE  = LVL_W'(1);
    localparam logic [LVL_W-1:0] LVL_LAST = LVL_W'(DEPTH - 1);
    localparam logic [PTR_W-1:0] PTR_END  = PTR_W'(DEPTH - 1);

    fill_state_e state_q, state_d;
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic do_push, do_pop;

    assign do_push = push && !is_full && !flush;
    assign do_pop  = pop && !is_empty && !flush;

    always_comb begin
        state_d = state_q;
        if (flush) begin
            state_d = FILL_EMPTY;
        end else begin
            unique case (state_q)
                FILL_EMPTY:
                    if (do_push) state_d = FILL_PARTIAL;
                FILL_PARTIAL:
                    if (do_push && !do_pop && level == LVL_LAST) state_d = FILL_FULL;
                    else if (do_pop && !do_push && level == LVL_ONE) state_d = FILL_EMPTY;
                FILL_FULL:
                    if (do_pop && !do_push) state_d = FILL_PARTIAL;
                default:
                    state_d = FILL_EMPTY;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FILL_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        is_empty = (state_q == FILL_EMPTY);
        is_full  = (state_q == FILL_FULL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PTR_END) ? '0 : wr_ptr + PTR_W'(1);
            if (do_pop)  rd_ptr <= (rd_ptr == PTR_END) ? '0 : rd_ptr + PTR_W'(1);
            if (do_push && !do_pop)      level <= level + LVL_W'(1);
            else if (do_pop && !do_push) level <= level - LVL_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    assign head = mem[rd_ptr];
endmodule

// File: rtl/uart_fifo_tracker.sv
module uart_fifo_tracker
    import uft_pkg::*;
#(
    parameter int TX_DEPTH = 16,
    parameter int RX_DEPTH = 16,
    localparam int TX_LVL_W = $clog2(TX_DEPTH + 1),
    localparam int RX_LVL_W = $clog2(RX_DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic        reg_re,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        tx_valid,
    input  logic        tx_ready,
    output logic [7:0]  tx_data,
    input  logic        rx_valid,
    output logic        rx_ready,
    input  logic [7:0]  rx_data,
    output logic        evt_tx_wmark,
    output logic        evt_tx_empty,
    output logic        evt_rx_wmark,
    output logic        evt_rx_ovf,
    output logic        tx_wmark_pend
);
    logic tx_en_q, rx_en_q, rx_idle_q;
    logic [THR_W-1:0] tx_thr_q, rx_thr_q;
    logic [TX_LVL_W-1:0] tx_lvl;
    logic [RX_LVL_W-1:0] rx_lvl;
    logic tx_full, tx_empty, rx_full, rx_empty;
    logic [7:0] rx_head;
    logic tx_push, tx_pop, tx_flush, rx_push, rx_pop, rx_flush;
    logic fctrl_wr;
    int unsigned tx_lvl_nx, rx_lvl_nx;

    assign fctrl_wr = reg_we && reg_addr == ADDR_FCTRL;
    assign tx_flush = fctrl_wr && reg_wdata[1];
    assign rx_flush = fctrl_wr && reg_wdata[0];
    assign tx_push  = reg_we && reg_addr == ADDR_WDATA && !tx_full;
    assign tx_valid = tx_en_q && !tx_empty;
    assign tx_pop   = tx_valid && tx_ready;
    assign rx_ready = rx_en_q && !rx_full;
    assign rx_push  = rx_valid && rx_ready;
    assign rx_pop   = reg_re && reg_addr == ADDR_RDATA && rx_en_q && !rx_empty;

    uft_byte_fifo #(.DEPTH(TX_DEPTH), .WIDTH(8)) i_tx_fifo (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush), .push(tx_push), .pop(tx_pop),
        .wdata(reg_wdata[7:0]), .head(tx_data), .level(tx_lvl),
        .is_empty(tx_empty), .is_full(tx_full)
    );

    uft_byte_fifo #(.DEPTH(RX_DEPTH), .WIDTH(8)) i_rx_fifo (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush), .push(rx_push), .pop(rx_pop),
        .wdata(rx_data), .head(rx_head), .level(rx_lvl),
        .is_empty(rx_empty), .is_full(rx_full)
    );

    always_comb begin
        tx_lvl_nx = 32'(tx_lvl) + (tx_push ? 32'd1 : 32'd0) - (tx_pop ? 32'd1 : 32'd0);
        rx_lvl_nx = 32'(rx_lvl) + (rx_push ? 32'd1 : 32'd0) - (rx_pop ? 32'd1 : 32'd0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_en_q  <= 1'b0;
            rx_en_q  <= 1'b0;
            tx_thr_q <= '0;
            rx_thr_q <= '0;
        end else if (reg_we) begin
            if (reg_addr == ADDR_CTRL) begin
                tx_en_q <= reg_wdata[0];
                rx_en_q <= reg_wdata[1];
            end
            if (fctrl_wr) begin
                tx_thr_q <= reg_wdata[TX_THR_LSB +: THR_W];
                rx_thr_q <= reg_wdata[RX_THR_LSB +: THR_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_tx_wmark  <= 1'b0;
            evt_tx_empty  <= 1'b0;
            evt_rx_wmark  <= 1'b0;
            evt_rx_ovf    <= 1'b0;
            tx_wmark_pend <= 1'b0;
            rx_idle_q     <= 1'b1;
        end else begin
            evt_tx_wmark <= tx_push && tx_lvl_nx >= 32'(tx_thr_q);
            evt_tx_empty <= tx_pop && !tx_push && !tx_flush && tx_lvl_nx == 0;
            evt_rx_wmark <= rx_push && !rx_flush && rx_lvl_nx >= 32'(rx_thr_q);
            evt_rx_ovf   <= rx_valid && rx_en_q && rx_full;
            if (tx_flush)
                tx_wmark_pend <= 1'b0;
            else if (tx_push && tx_lvl_nx >= 32'(tx_thr_q))
                tx_wmark_pend <= 1'b1;
            else if (tx_pop && tx_lvl_nx < 32'(tx_thr_q))
                tx_wmark_pend <= 1'b0;
            if (rx_flush)
                rx_idle_q <= 1'b1;
            else if (rx_push)
                rx_idle_q <= 1'b0;
            else if (rx_pop && rx_lvl_nx == 0)
                rx_idle_q <= 1'b1;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_re) begin
            case (reg_addr)
                ADDR_CTRL:  reg_rdata = {30'd0, rx_en_q, tx_en_q};
                ADDR_STAT:  reg_rdata = {26'd0, rx_empty, rx_idle_q, !tx_valid,
                                         tx_empty, rx_full, tx_full};
                ADDR_RDATA: reg_rdata = rx_empty ? 32'd0 : {24'd0, rx_head};
                ADDR_FCTRL: begin
                    reg_rdata[TX_THR_LSB +: THR_W] = tx_thr_q;
                    reg_rdata[RX_THR_LSB +: THR_W] = rx_thr_q;
                end
                ADDR_FSTAT: begin
                    reg_rdata[TX_LVL_LSB +: 5] = 5'(tx_lvl);
                    reg_rdata[RX_LVL_LSB +: 5] = 5'(rx_lvl);
                end
                default:    reg_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/uft_checker.sv
module uft_checker #(
    parameter int TX_DEPTH = 16,
    parameter int RX_DEPTH = 16,
    localparam int TX_LVL_W = $clog2(TX_DEPTH + 1),
    localparam int RX_LVL_W = $clog2(RX_DEPTH + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                tx_valid,
    input logic                rx_valid,
    input logic                rx_ready,
    input logic                evt_tx_empty,
    input logic                evt_rx_ovf,
    input logic                tx_wmark_pend,
    input logic [TX_LVL_W-1:0] tx_lvl,
    input logic [RX_LVL_W-1:0] rx_lvl,
    input logic [4:0]          tx_thr_q,
    input logic                tx_full,
    input logic                tx_empty,
    input logic                rx_full,
    input logic                rx_empty,
    input logic                rx_idle_q
);
    always_comb begin
        if (rst_n) begin
            assert_tx_bound_R1: assert (32'(tx_lvl) <= TX_DEPTH)
                else $error("tx level above depth");
            assert_flag_excl_R4: assert (!(tx_full && tx_empty))
                else $error("tx full and empty together");
        end
    end

    assert_tx_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> tx_lvl != 0);

    assert_empty_evt_R4: assert property (@(posedge clk) disable iff (!rst_n)
        evt_tx_empty |-> tx_lvl == 0);

    assert_wm_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_wmark_pend) |-> (tx_lvl == 0 || 32'(tx_lvl) < 32'($past(tx_thr_q))));

    assert_no_accept_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full |-> !rx_ready);

    assert_rx_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        32'(rx_lvl) <= RX_DEPTH);

    assert_ovf_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        evt_rx_ovf |-> $past(rx_valid) && $past(rx_full));

    assert_idle_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_idle_q |-> rx_empty);
endmodule

bind uart_fifo_tracker uft_checker #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) i_uft_chk (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .evt_tx_empty(evt_tx_empty), .evt_rx_ovf(evt_rx_ovf),
    .tx_wmark_pend(tx_wmark_pend), .tx_lvl(tx_lvl), .rx_lvl(rx_lvl),
    .tx_thr_q(tx_thr_q), .tx_full(tx_full), .tx_empty(tx_empty),
    .rx_full(rx_full), .rx_empty(rx_empty), .rx_idle_q(rx_idle_q)
);

// File: tb/test_uart_fifo_tracker.sv
module test_uart_fifo_tracker;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;

    localparam int OP_NONE   = 0;
    localparam int OP_WDATA  = 1;
    localparam int OP_RDATA  = 2;
    localparam int OP_RSTAT  = 3;
    localparam int OP_RFSTAT = 4;
    localparam int OP_WCTRL  = 5;
    localparam int OP_WFCTRL = 6;
    localparam int OP_RCTRL  = 7;
    localparam int OP_RFCTRL = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_we = 0, reg_re = 0, tx_ready = 0, rx_valid = 0;
    logic [2:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic [7:0] rx_data = '0, tx_data;
    logic tx_valid, rx_ready, evt_tx_wmark, evt_tx_empty, evt_rx_wmark, evt_rx_ovf, tx_wmark_pend;

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    byte unsigned txq[$], rxq[$];
    bit m_txen = 0, m_rxen = 0, m_pend = 0, m_rxidle = 1;
    int m_txthr = 0, m_rxthr = 0;
    bit e_txwm = 0, e_txempty = 0, e_rxwm = 0, e_ovf = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_fifo_tracker i_uart_fifo_tracker (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
        .evt_tx_wmark(evt_tx_wmark), .evt_tx_empty(evt_tx_empty), .evt_rx_wmark(evt_rx_wmark),
        .evt_rx_ovf(evt_rx_ovf), .tx_wmark_pend(tx_wmark_pend)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_status();
        bit txvalid = m_txen && txq.size() > 0;
        return {26'd0, rxq.size() == 0, m_rxidle, !txvalid, txq.size() == 0,
                rxq.size() == DEPTH, txq.size() == DEPTH};
    endfunction

    function automatic logic [31:0] exp_fstat();
        return (32'(txq.size()) & 32'h1F) | ((32'(rxq.size()) & 32'h1F) << 16);
    endfunction

    function automatic logic [2:0] op_addr(int op);
        case (op)
            OP_WDATA:            return 3'd3;
            OP_RDATA:            return 3'd2;
            OP_RSTAT:            return 3'd1;
            OP_RFSTAT:           return 3'd5;
            OP_WFCTRL, OP_RFCTRL: return 3'd4;
            default:             return 3'd0;
        endcase
    endfunction

    // Called at a negative edge; consumes exactly one clock cycle.
    task automatic run_cycle(int op, logic [31:0] wd, logic txr, logic rxv, logic [7:0] rxd);
        bit push, txfire, flush_tx, flush_rx, rxfull, rxfire, pop;
        int n;
        reg_we    = (op == OP_WDATA || op == OP_WCTRL || op == OP_WFCTRL);
        reg_re    = (op == OP_RDATA || op == OP_RSTAT || op == OP_RFSTAT ||
                     op == OP_RCTRL || op == OP_RFCTRL);
        reg_addr  = op_addr(op);
        reg_wdata = wd;
        tx_ready  = txr;
        rx_valid  = rxv;
        rx_data   = rxd;
        #1;
        chk("R3 tx_valid", 32'(tx_valid), 32'(m_txen && txq.size() > 0));
        if (tx_valid && txq.size() > 0) chk("R3 tx_data order", 32'(tx_data), 32'(txq[0]));
        chk("R6 rx_ready", 32'(rx_ready), 32'(m_rxen && rxq.size() < DEPTH));
        case (op)
            OP_RSTAT:  chk("R4/R8 status", reg_rdata, exp_status());
            OP_RFSTAT: chk("R1 fifo status", reg_rdata, exp_fstat());
            OP_RDATA:  chk("R7 rdata", reg_rdata, rxq.size() > 0 ? 32'(rxq[0]) : 32'd0);
            OP_RCTRL:  chk("R3/R6 ctrl", reg_rdata, {30'd0, m_rxen, m_txen});
            OP_RFCTRL: chk("R5 fifo ctrl", reg_rdata, (32'(m_txthr) << 16) | (32'(m_rxthr) << 8));
            default:   chk("R9 idle rdata", reg_rdata, 32'd0);
        endcase
        // model step
        push     = (op == OP_WDATA) && txq.size() < DEPTH;
        flush_tx = (op == OP_WFCTRL) && wd[1];
        flush_rx = (op == OP_WFCTRL) && wd[0];
        txfire   = m_txen && txq.size() > 0 && txr;
        if (txfire) void'(txq.pop_front());
        if (push) txq.push_back(wd[7:0]);
        n = txq.size();
        e_txwm    = push && n >= m_txthr;
        e_txempty = txfire && !push && !flush_tx && n == 0;
        if (flush_tx) m_pend = 0;
        else if (push && n >= m_txthr) m_pend = 1;
        else if (txfire && n < m_txthr) m_pend = 0;
        if (flush_tx) txq.delete();
        rxfull = rxq.size() == DEPTH;
        rxfire = rxv && m_rxen && !rxfull;
        pop    = (op == OP_RDATA) && m_rxen && rxq.size() > 0;
        e_ovf  = rxv && m_rxen && rxfull;
        if (pop) void'(rxq.pop_front());
        if (rxfire) rxq.push_back(rxd);
        n = rxq.size();
        e_rxwm = rxfire && !flush_rx && n >= m_rxthr;
        if (flush_rx) m_rxidle = 1;
        else if (rxfire) m_rxidle = 0;
        else if (pop && n == 0) m_rxidle = 1;
        if (flush_rx) rxq.delete();
        if (op == OP_WCTRL) begin m_txen = wd[0]; m_rxen = wd[1]; end
        if (op == OP_WFCTRL) begin m_txthr = int'(wd[20:16]); m_rxthr = int'(wd[12:8]); end
        @(posedge clk);
        @(negedge clk);
        chk("R2 evt_tx_wmark", 32'(evt_tx_wmark), 32'(e_txwm));
        chk("R2 tx_wmark_pend", 32'(tx_wmark_pend), 32'(m_pend));
        chk("R4 evt_tx_empty", 32'(evt_tx_empty), 32'(e_txempty));
        chk("R11 evt_rx_wmark", 32'(evt_rx_wmark), 32'(e_rxwm));
        chk("R10 evt_rx_ovf", 32'(evt_rx_ovf), 32'(e_ovf));
        reg_we = 0; reg_re = 0; tx_ready = 0; rx_valid = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state at the ports and in the status word
        reg_re = 1; reg_addr = 3'd1; #1;
        chk("R9 status reset", reg_rdata, 32'h3C);
        reg_addr = 3'd5; #1;
        chk("R9 levels reset", reg_rdata, 32'h0);
        reg_re = 0;
        chk("R9 events low", {27'd0, evt_tx_wmark, evt_tx_empty, evt_rx_wmark, evt_rx_ovf, tx_wmark_pend}, 32'd0);
        @(negedge clk);
        // thresholds: tx 4, rx 3
        run_cycle(OP_WFCTRL, (32'd4 << 16) | (32'd3 << 8), 0, 0, 0);
        run_cycle(OP_RFCTRL, 0, 0, 0, 0);
        // R1: fill transmit queue while disabled, 17th byte dropped
        for (int i = 0; i < 17; i++) run_cycle(OP_WDATA, 32'(8'hA0 + i), 1, 0, 0);
        run_cycle(OP_RFSTAT, 0, 0, 0, 0);
        chk("R1 full level", exp_fstat() & 32'h1F, 32'd16);
        run_cycle(OP_RSTAT, 0, 0, 0, 0);
        // R3/R4: enable and drain; empty event at the end
        run_cycle(OP_WCTRL, 32'd3, 1, 0, 0);
        for (int i = 0; i < 17; i++) run_cycle(OP_NONE, 0, 1, 0, 0);
        run_cycle(OP_RSTAT, 0, 0, 0, 0);
        // R6/R10/R11: fill receive queue and overflow
        for (int i = 0; i < 18; i++) run_cycle(OP_NONE, 0, 0, 1, 8'(8'h30 + i));
        run_cycle(OP_RSTAT, 0, 0, 1, 8'h77);
        // R7: read while receive disabled does not pop
        run_cycle(OP_WCTRL, 32'd1, 0, 0, 0);
        run_cycle(OP_RDATA, 0, 0, 0, 0);
        run_cycle(OP_RFSTAT, 0, 0, 0, 0);
        run_cycle(OP_WCTRL, 32'd3, 0, 0, 0);
        // R8: drain receive queue by reads
        for (int i = 0; i < 17; i++) run_cycle(OP_RDATA, 0, 0, 0, 0);
        run_cycle(OP_RSTAT, 0, 0, 0, 0);
        // R5: flushes
        for (int i = 0; i < 6; i++) run_cycle(OP_WDATA, 32'(i), 0, 1, 8'(i));
        run_cycle(OP_WFCTRL, (32'd4 << 16) | 32'd3, 0, 1, 8'h55);
        run_cycle(OP_RFSTAT, 0, 0, 0, 0);
        run_cycle(OP_RSTAT, 0, 0, 0, 0);
        // random phase
        for (int c = 0; c < 20000; c++) begin
            int bias = (c / 400) % 3;
            int r = int'($urandom % 100);
            int op;
            logic [31:0] wd = $urandom;
            logic txr = (bias == 0) ? ($urandom % 4 == 0) : (bias == 1) ? ($urandom % 2 == 0) : ($urandom % 8 != 0);
            logic rxv = (bias == 2) ? ($urandom % 4 == 0) : ($urandom % 2 == 0);
            if (r < 40)      op = OP_WDATA;
            else if (r < 65) op = OP_RDATA;
            else if (r < 72) op = OP_RSTAT;
            else if (r < 79) op = OP_RFSTAT;
            else if (r < 81) begin op = OP_WCTRL; wd = ($urandom % 5 == 0) ? ($urandom % 4) : 32'd3; end
            else if (r < 83) begin
                op = OP_WFCTRL;
                wd = (32'($urandom % 18) << 16) | (32'($urandom % 18) << 8) |
                     (($urandom % 6 == 0) ? 32'($urandom % 4) : 32'd0);
            end
            else if (r < 85) op = OP_RCTRL;
            else if (r < 87) op = OP_RFCTRL;
            else             op = OP_NONE;
            run_cycle(op, wd, txr, rxv, 8'($urandom));
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule